// File: doc/BRIEF.md
# Bit-Interleaving Dual-Stream Link Multiplexer

The block merges two single-bit serial streams into one line running at twice their rate, and contains the matching receiver that splits the line back into its two streams. It runs on the line-rate clock. A slot register alternates between the two channels on every cycle. One bit from each channel is taken in the same cycle. The bit from the first channel goes onto the line in the next cycle, and the bit from the second channel goes out one cycle later in inverted form. Because of that inversion, an idle line (both channels sending logic 0) carries an alternating 0/1 pattern. That pattern gives the line steady transitions, and it gives the receiver a marker to find the pair boundary.

The receiver looks at both possible pair alignments at once. For each alignment it counts consecutive pairs that match the idle marker, which is a 0 in the first slot followed by a 1 in the second. When one alignment reaches a programmable count, the receiver locks to it. From then on it delivers every pair: the first-slot bit unchanged and the second-slot bit inverted again, with a one-cycle strobe once every two cycles.

On the transmit side, each channel uses valid/ready. Both readies rise together on every other cycle, and a bit is taken only in a cycle where ready is high. There is no back-pressure beyond this fixed cadence. If valid is low in a ready cycle, that channel sends its idle level for the pair. The receive side has no ready, because the line cannot be paused, so the consumer must take every strobe.

Top module: `bitlink_mux`

## Requirements
- R1: After reset, `a_ready` and `b_ready` are high together in the first cycle and then toggle on every clock, so they are high every other cycle. A bit is taken when its valid and ready are both high at a rising edge.
- R2: A first-channel bit taken at edge k is driven on `line_out` from edge k until edge k+1. The second-channel bit taken at the same edge k is driven, inverted, from edge k+1 until edge k+2.
- R3: If a channel's valid is low in a ready cycle, that channel sends logic 0 for that pair. On the line this shows as 0 in the first slot and 1 in the second slot.
- R4: `rx_lock` rises only after `lock_len` consecutive pairs of one alignment have carried 0 then 1 on `line_in`. A `lock_len` of 0 acts as 1. The receiver never locks earlier than that.
- R5: Once `rx_lock` is high, it stays high until reset.
- R6: While locked, `rx_a_valid` and `rx_b_valid` pulse together for one cycle every two cycles. `rx_a_data` is the first-slot bit of the pair and `rx_b_data` is the inverse of the second-slot bit. The strobes are never high while unlocked.
- R7: During and right after reset, `line_out`, `rx_lock`, `rx_a_valid` and `rx_b_valid` are 0, and both readies are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_len | input | CNT_W | Number of consecutive marker pairs needed for lock |
| a_valid | input | 1 | First channel bit present |
| a_data | input | 1 | First channel bit |
| a_ready | output | 1 | First channel bit is taken this cycle if valid |
| b_valid | input | 1 | Second channel bit present |
| b_data | input | 1 | Second channel bit |
| b_ready | output | 1 | Second channel bit is taken this cycle if valid |
| line_out | output | 1 | Interleaved double-rate serial output |
| line_in | input | 1 | Interleaved serial input to the receiver |
| rx_lock | output | 1 | Receiver has found the pair alignment |
| rx_a_valid | output | 1 | Recovered first-channel bit strobe |
| rx_a_data | output | 1 | Recovered first-channel bit |
| rx_b_valid | output | 1 | Recovered second-channel bit strobe |
| rx_b_data | output | 1 | Recovered second-channel bit, polarity restored |

## Verification
A first-channel bit is on the line in the cycle right after the edge that takes it, and the inverted second-channel bit is on the line one cycle after that. The bench samples `line_out` at the falling edges that fall inside those two windows. On the receive side, a pair is delivered on the rising edge after its second slot arrives at `line_in`, plus the loopback delay the bench adds. That delay is a random value from 0 to 3 cycles and sets the start phase. Because of this delay, received pairs are matched in order through a queue rather than at a fixed cycle. The lock time is bounded from both sides: the bench checks at edge 2·`lock_len`−3 that lock has not yet come, and then waits a bounded window for it to arrive.

// File: rtl/bitlink_pkg.sv
package bitlink_pkg;
  typedef enum logic {SLOT_FIRST = 1'b0, SLOT_SECOND = 1'b1} slot_e;
  localparam logic IDLE_LEVEL = 1'b0;
endpackage

// File: rtl/bitlink_interleave.sv
module bitlink_interleave
  import bitlink_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic a_valid,
  input  logic a_data,
  input  logic b_valid,
  input  logic b_data,
  output logic take,
  output logic line_out
);
  slot_e slot_q;
  logic  line_q;
  logic  b_hold_q;

  assign take     = (slot_q == SLOT_FIRST);
  assign line_out = line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q   <= SLOT_FIRST;
      line_q   <= 1'b0;
      b_hold_q <= 1'b0;
    end else begin
      slot_q <= (slot_q == SLOT_FIRST) ? SLOT_SECOND : SLOT_FIRST;
      if (slot_q == SLOT_FIRST) begin
        line_q   <= a_valid ? a_data : IDLE_LEVEL;
        b_hold_q <= ~(b_valid ? b_data : IDLE_LEVEL);
      end else begin
        line_q   <= b_hold_q;
      end
    end
  end

  // R1
  take_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take);
  // R2
  first_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && a_valid) |=> (line_out == $past(a_data)));
  // R2
  second_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && b_valid) |=> ##1 (line_out == !$past(b_data, 2)));
  // R3
  idle_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !a_valid) |=> !line_out);
endmodule

// File: rtl/bitlink_phase_hunt.sv
module bitlink_phase_hunt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] lock_len,
  input  logic             phase_t,
  input  logic             prev_bit,
  input  logic             cur_bit,
  output logic             locked,
  output logic             sel_phase
);
  localparam int NPH = 2;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] eff_len;
  logic             marker;
  logic [NPH-1:0]   hit;
  logic             lock_q;
  logic             sel_q;

  assign eff_len   = (lock_len == '0) ? CNT_W'(1) : lock_len;
  assign marker    = !prev_bit && cur_bit;
  assign locked    = lock_q;
  assign sel_phase = sel_q;

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    logic [CNT_W-1:0] cnt_q;
    logic             mine;
    assign mine   = (phase_t == 1'(p));
    assign hit[p] = mine && marker && (({1'b0, cnt_q} + 1'b1) >= {1'b0, eff_len});
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else if (mine && !lock_q) begin
        if (marker) cnt_q <= (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
        else        cnt_q <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      sel_q  <= 1'b0;
    end else if (!lock_q && (hit != '0)) begin
      lock_q <= 1'b1;
      sel_q  <= phase_t;
    end
  end

  // R5
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  // R4
  lock_needs_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(marker));
  // R5
  sel_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && $past(lock_q)) |-> $stable(sel_q));
endmodule

// File: rtl/bitlink_split.sv
module bitlink_split (
  input  logic clk,
  input  logic rst_n,
  input  logic locked,
  input  logic sel_phase,
  input  logic phase_t,
  input  logic prev_bit,
  input  logic cur_bit,
  output logic a_valid,
  output logic a_data,
  output logic b_valid,
  output logic b_data
);
  logic strobe_q, a_q, b_q;
  logic fire;

  assign fire    = locked && (phase_t == sel_phase);
  assign a_valid = strobe_q;
  assign b_valid = strobe_q;
  assign a_data  = a_q;
  assign b_data  = b_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      a_q      <= 1'b0;
      b_q      <= 1'b0;
    end else begin
      strobe_q <= fire;
      if (fire) begin
        a_q <= prev_bit;
        b_q <= ~cur_bit;
      end
    end
  end

  // R6
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |=> !strobe_q);
  // R6
  strobe_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |-> locked);
  // R6
  strobe_cadence_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_q && locked) |=> ##1 strobe_q);
endmodule

// File: rtl/bitlink_mux.sv
module bitlink_mux #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] lock_len,
  input  logic             a_valid,
  input  logic             a_data,
  output logic             a_ready,
  input  logic             b_valid,
  input  logic             b_data,
  output logic             b_ready,
  output logic             line_out,
  input  logic             line_in,
  output logic             rx_lock,
  output logic             rx_a_valid,
  output logic             rx_a_data,
  output logic             rx_b_valid,
  output logic             rx_b_data
);
  logic take;
  logic prev_q;
  logic phase_q;
  logic sel_phase;

  assign a_ready = take;
  assign b_ready = take;

  bitlink_interleave u_tx (
    .clk(clk), .rst_n(rst_n),
    .a_valid(a_valid), .a_data(a_data),
    .b_valid(b_valid), .b_data(b_data),
    .take(take), .line_out(line_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      phase_q <= 1'b0;
    end else begin
      prev_q  <= line_in;
      phase_q <= ~phase_q;
    end
  end

  bitlink_phase_hunt #(.CNT_W(CNT_W)) u_hunt (
    .clk(clk), .rst_n(rst_n), .lock_len(lock_len),
    .phase_t(phase_q), .prev_bit(prev_q), .cur_bit(line_in),
    .locked(rx_lock), .sel_phase(sel_phase)
  );

  bitlink_split u_split (
    .clk(clk), .rst_n(rst_n),
    .locked(rx_lock), .sel_phase(sel_phase), .phase_t(phase_q),
    .prev_bit(prev_q), .cur_bit(line_in),
    .a_valid(rx_a_valid), .a_data(rx_a_data),
    .b_valid(rx_b_valid), .b_data(rx_b_data)
  );

  // R7
  reset_quiet_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> (!line_out && !rx_lock && !rx_a_valid && a_ready));
endmodule

// File: tb/tb_bitlink_mux.sv
module tb_bitlink_mux;
  localparam int CNT_W = 8;
  localparam int LEN   = 8;
  localparam int NPAIRS = 3000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CNT_W-1:0] lock_len = CNT_W'(LEN);
  logic a_valid = 1'b0, a_data = 1'b0, b_valid = 1'b0, b_data = 1'b0;
  logic a_ready, b_ready, line_out, line_in;
  logic rx_lock, rx_a_valid, rx_a_data, rx_b_valid, rx_b_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit started = 1'b0;
  bit driving = 1'b0;
  logic [1:0] exp_q[$];
  int dly;
  logic [3:0] dline = '0;

  always #5 clk = ~clk;

  bitlink_mux #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .lock_len(lock_len),
    .a_valid(a_valid), .a_data(a_data), .a_ready(a_ready),
    .b_valid(b_valid), .b_data(b_data), .b_ready(b_ready),
    .line_out(line_out), .line_in(line_in),
    .rx_lock(rx_lock), .rx_a_valid(rx_a_valid), .rx_a_data(rx_a_data),
    .rx_b_valid(rx_b_valid), .rx_b_data(rx_b_data)
  );

  always @(posedge clk) dline <= {dline[2:0], line_out};
  assign line_in = (dly == 0) ? line_out : dline[dly-1];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // monitor: scoreboard side
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_a_valid != rx_b_valid)
        chk(1'b0, "R6 strobes together", int'(rx_a_valid), int'(rx_b_valid));
      if (rx_a_valid) begin
        if (!rx_lock) chk(1'b0, "R6 strobe while unlocked", 1, 0);
        if (!started && !rx_a_data && !rx_b_data) begin
        end else begin
          started = 1'b1;
          if (exp_q.size() == 0) begin
            chk(1'b0, "R6 unexpected pair", int'({rx_a_data, rx_b_data}), -1);
          end else begin
            logic [1:0] e;
            e = exp_q.pop_front();
            chk(rx_a_data == e[1], "R6 first channel bit", int'(rx_a_data), int'(e[1]));
            chk(rx_b_data == e[0], "R6 second channel bit", int'(rx_b_data), int'(e[0]));
          end
        end
      end
    end
  end

  // driver
  initial begin
    dly = $urandom_range(0, 3);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R7 reset state
    chk(line_out == 1'b0, "R7 line_out in reset", int'(line_out), 0);
    chk(rx_lock == 1'b0, "R7 lock in reset", int'(rx_lock), 0);
    chk(rx_a_valid == 1'b0, "R7 strobe in reset", int'(rx_a_valid), 0);
    chk(a_ready && b_ready, "R7 ready in reset", int'(a_ready), 1);
    rst_n = 1'b1;
    // R1 cadence of ready
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(a_ready == i[0] && b_ready == i[0], "R1 ready cadence", int'(a_ready), i[0]);
    end
    // R3 idle line pattern: slots 0 then 1
    @(negedge clk);
    if (a_ready) @(negedge clk);
    chk(line_out == 1'b0, "R3 idle first slot", int'(line_out), 0);
    @(negedge clk);
    chk(line_out == 1'b1, "R3 idle second slot", int'(line_out), 1);
  end

  initial begin
    bit first;
    bit have_last;
    logic la, lb;
    int wait_n;
    @(posedge rst_n);
    // R4: no early lock (rst_n rises at a negedge)
    repeat (2*LEN - 3) @(posedge clk);
    @(negedge clk);
    chk(rx_lock == 1'b0, "R4 no early lock", int'(rx_lock), 0);
    wait_n = 0;
    while (!rx_lock && wait_n < 40) begin @(negedge clk); wait_n++; end
    chk(rx_lock == 1'b1, "R4 lock on idle markers", int'(rx_lock), 1);
    repeat (6) @(negedge clk);
    first = 1'b1;
    have_last = 1'b0;
    la = 1'b0; lb = 1'b0;
    for (int n = 0; n < 2*NPAIRS; n++) begin
      @(negedge clk);
      if (a_ready) begin
        if (have_last)
          chk(line_out == ~lb, "R2 inverted second slot", int'(line_out), int'(~lb));
        a_valid = first ? 1'b1 : ($urandom_range(0, 7) != 0);
        b_valid = ($urandom_range(0, 7) != 0);
        a_data  = first ? 1'b1 : 1'($urandom_range(0, 1));
        b_data  = 1'($urandom_range(0, 1));
        la = a_valid ? a_data : 1'b0;
        lb = b_valid ? b_data : 1'b0;
        exp_q.push_back({la, lb});
        have_last = 1'b1;
        first = 1'b0;
      end else if (have_last) begin
        chk(line_out == la, "R2 first slot on line", int'(line_out), int'(la));
        if (!a_valid) chk(line_out == 1'b0, "R3 idle first channel", int'(line_out), 0);
      end
    end
    @(negedge clk);
    a_valid = 1'b0; b_valid = 1'b0; a_data = 1'b0; b_data = 1'b0;
    wait_n = 0;
    while (exp_q.size() != 0 && wait_n < 40) begin @(negedge clk); wait_n++; end
    chk(exp_q.size() == 0, "R6 all pairs recovered", exp_q.size(), 0);
    chk(rx_lock == 1'b1, "R5 lock held", int'(rx_lock), 1);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end
endmodule